// File: doc/BRIEF.md
# Dual-Loop Phase Detector and Lock Monitor

This block holds the digital part of the phase detection for two synthesizer loops: a low band and a high band. Each loop compares a reference pulse train against a divided feedback pulse train. It drives a tri-state charge-pump command: drive high, drive low, or release to high impedance. The direction depends on which edge arrives first and on a polarity bit, which suits either sign of oscillator and filter gain. All inputs are sampled on the reference-oscillator clock, and every measurement is counted in periods of that clock.

The block measures the phase error of every comparison as the number of oscillator clocks between the first and the second edge. From that count it keeps one lock flag per loop, with hysteresis. The two flags, together with the power-save inputs, form one lock indication. A single output pin carries either that lock indication or one of the four raw comparison inputs, for bench monitoring. A loop in power save releases its drive. When the loop leaves power save, its first comparison is kept off the drive, so that a stale phase relation cannot kick the oscillator.

Top module: `pd_lock_top`

## Requirements
- R1: Drive direction. With the polarity bit at 1, a reference edge that arrives first gives drive_en=1 and drive_lvl=1, and a feedback edge that arrives first gives drive_en=1 and drive_lvl=0. With the polarity bit at 0, the level is inverted.
- R2: When the reference edge and the feedback edge arrive in the same clock, the drive stays released: drive_en=0 throughout the comparison.
- R3: For a lead of d clocks (d >= 1), drive_en is 1 for exactly d consecutive cycles, starting in the cycle after the first edge. This holds even at d=1 and whatever the lock state, so there is no dead zone.
- R4: A loop's lock flag clears as soon as a comparison's error count reaches the unlock threshold (default 3 clocks). With default parameters, a comparison with a lead of 3 or more clocks leaves the lock output at 0.
- R5: A lock flag sets only after the lock-run count (default 3) of consecutive comparisons whose error is no greater than the lock threshold (default 1 clock). An error between the two thresholds breaks the run but does not clear a lock flag that is already set.
- R6: With mon_en=0, lock_out is 1 exactly when every loop is either locked or in power save, and 0 otherwise. It is registered, and one cycle behind the flags.
- R7: A loop whose save input is 1 holds drive_en at 0 whatever pulses arrive, and counts as locked in lock_out.
- R8: After a loop's save input returns to 0, the first complete comparison produces no drive. The comparisons after it drive normally.
- R9: With mon_en=1, lock_out is the registered copy of one raw input, selected by tsel, where tsel[0] chooses the band (0 low, 1 high) and tsel[1] chooses the signal (0 reference, 1 feedback): 00 ref_lo, 01 ref_hi, 10 fb_lo, 11 fb_hi.
- R10: After reset both drives are released, both lock flags are clear, and lock_out is 0 while neither loop is in power save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_lo | input | 1 | Low-band reference pulse |
| fb_lo | input | 1 | Low-band divided feedback pulse |
| ref_hi | input | 1 | High-band reference pulse |
| fb_hi | input | 1 | High-band divided feedback pulse |
| pol_lo | input | 1 | Low-band drive polarity |
| pol_hi | input | 1 | High-band drive polarity |
| save_lo | input | 1 | Low-band power save, active high |
| save_hi | input | 1 | High-band power save, active high |
| mon_en | input | 1 | 1 routes a monitored input to lock_out |
| tsel | input | 2 | Monitor select: [0] band, [1] reference/feedback |
| drive_en_lo | output | 1 | Low-band drive enable (0 = high impedance) |
| drive_lvl_lo | output | 1 | Low-band drive level while enabled |
| drive_en_hi | output | 1 | High-band drive enable (0 = high impedance) |
| drive_lvl_hi | output | 1 | High-band drive level while enabled |
| lock_out | output | 1 | Combined lock or monitored signal |

## Verification
The properties assume that the pulse inputs are clean synchronous levels. They also assume that polarity bits are not changed in the middle of a drive pulse, and that save, mon_en and tsel are stable for at least one clock before the result is read. The stimulus raises each pulse for exactly one clock, on the falling clock edge. It starts each comparison only after the previous one has finished and the drive has settled. It changes polarity, save and selection only between comparisons, so every comparison has a single, known lead.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int NUM_LOOPS = 2;

  typedef struct packed {
    logic en;
    logic lvl;
  } drive_t;

  typedef enum logic [1:0] {
    MON_REF_LO = 2'b00,
    MON_REF_HI = 2'b01,
    MON_FB_LO  = 2'b10,
    MON_FB_HI  = 2'b11
  } mon_sel_e;
endpackage

// File: rtl/pd_phase_cmp.sv
module pd_phase_cmp
  import pd_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic             pol,
  input  logic             save,
  output drive_t           drv,
  output logic             pending,
  output logic [ERR_W-1:0] err_cnt,
  output logic             done
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic ref_q, fb_q;
  logic up_ff, dn_ff;
  logic up_seen, dn_seen, up_nxt, dn_nxt;
  logic sup;
  logic [ERR_W-1:0] cnt;

  // Rising-edge detection against the previous sample
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
    end
  end

  // Two-flop detector; both set means the comparison is complete
  always_comb begin
    up_seen = up_ff | (ref_in & ~ref_q);
    dn_seen = dn_ff | (fb_in & ~fb_q);
    done    = up_seen & dn_seen & ~save;
    up_nxt  = up_seen & ~(up_seen & dn_seen);
    dn_nxt  = dn_seen & ~(up_seen & dn_seen);
  end

  always_ff @(posedge clk) begin
    if (rst || save) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
      cnt   <= '0;
    end else begin
      up_ff <= up_nxt;
      dn_ff <= dn_nxt;
      if (up_nxt | dn_nxt)
        cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      else
        cnt <= '0;
    end
  end

  // First comparison after power save is kept off the drive
  always_ff @(posedge clk) begin
    if (rst)       sup <= 1'b0;
    else if (save) sup <= 1'b1;
    else if (done) sup <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv <= '0;
    end else begin
      drv.en  <= ~save & ~sup & (up_nxt ^ dn_nxt);
      drv.lvl <= ~save & ~sup & (up_nxt ^ dn_nxt) & (up_nxt ? pol : ~pol);
    end
  end

  assign pending = up_ff | dn_ff;
  assign err_cnt = cnt;
endmodule

// File: rtl/pd_lock_det.sv
module pd_lock_det #(
  parameter int ERR_W     = 8,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 1,
  parameter int LOCK_RUN  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save,
  input  logic             pending,
  input  logic [ERR_W-1:0] err_cnt,
  input  logic             done,
  output logic             locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);

  logic [RUN_W-1:0] run;
  logic             big_err, small_err;

  assign big_err   = pending && (err_cnt >= ERR_W'(UNLOCK_TH));
  assign small_err = err_cnt <= ERR_W'(LOCK_TH);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (!save) begin
      if (big_err) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (done) begin
        if (small_err) begin
          if (run >= RUN_LAST) locked <= 1'b1;
          run <= (run == RUN_FULL) ? run : run + 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pd_pin_mux.sv
module pd_pin_mux
  import pd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mon_en,
  input  logic [1:0]           tsel,
  input  logic                 lock_all,
  input  logic [NUM_LOOPS-1:0] ref_v,
  input  logic [NUM_LOOPS-1:0] fb_v,
  output logic                 pin
);
  logic mon_bit;

  always_comb begin
    unique case (mon_sel_e'(tsel))
      MON_REF_LO: mon_bit = ref_v[0];
      MON_REF_HI: mon_bit = ref_v[1];
      MON_FB_LO:  mon_bit = fb_v[0];
      MON_FB_HI:  mon_bit = fb_v[1];
      default:    mon_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= mon_en ? mon_bit : lock_all;
  end
endmodule

// File: rtl/pd_lock_top.sv
module pd_lock_top
  import pd_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_TH   = 1,
  parameter int LOCK_RUN  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_lo,
  input  logic       fb_lo,
  input  logic       ref_hi,
  input  logic       fb_hi,
  input  logic       pol_lo,
  input  logic       pol_hi,
  input  logic       save_lo,
  input  logic       save_hi,
  input  logic       mon_en,
  input  logic [1:0] tsel,
  output logic       drive_en_lo,
  output logic       drive_lvl_lo,
  output logic       drive_en_hi,
  output logic       drive_lvl_hi,
  output logic       lock_out
);
  logic [NUM_LOOPS-1:0] ref_v, fb_v, pol_v, save_v, lk_v;
  drive_t               drv_v [NUM_LOOPS];

  assign ref_v  = {ref_hi, ref_lo};
  assign fb_v   = {fb_hi, fb_lo};
  assign pol_v  = {pol_hi, pol_lo};
  assign save_v = {save_hi, save_lo};

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    logic             pend;
    logic             cmp_done;
    logic [ERR_W-1:0] err;

    pd_phase_cmp #(.ERR_W(ERR_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .ref_in  (ref_v[g]),
      .fb_in   (fb_v[g]),
      .pol     (pol_v[g]),
      .save    (save_v[g]),
      .drv     (drv_v[g]),
      .pending (pend),
      .err_cnt (err),
      .done    (cmp_done)
    );

    pd_lock_det #(
      .ERR_W(ERR_W), .UNLOCK_TH(UNLOCK_TH),
      .LOCK_TH(LOCK_TH), .LOCK_RUN(LOCK_RUN)
    ) u_det (
      .clk     (clk),
      .rst     (rst),
      .save    (save_v[g]),
      .pending (pend),
      .err_cnt (err),
      .done    (cmp_done),
      .locked  (lk_v[g])
    );
  end

  pd_pin_mux u_mux (
    .clk      (clk),
    .rst      (rst),
    .mon_en   (mon_en),
    .tsel     (tsel),
    .lock_all (&(lk_v | save_v)),
    .ref_v    (ref_v),
    .fb_v     (fb_v),
    .pin      (lock_out)
  );

  assign drive_en_lo  = drv_v[0].en;
  assign drive_lvl_lo = drv_v[0].lvl;
  assign drive_en_hi  = drv_v[1].en;
  assign drive_lvl_hi = drv_v[1].lvl;
endmodule

// File: rtl/pd_lock_top_chk.sv
module pd_lock_top_chk (
  input logic       clk,
  input logic       rst,
  input logic       fb_hi,
  input logic       pol_lo,
  input logic       save_lo,
  input logic       save_hi,
  input logic       mon_en,
  input logic [1:0] tsel,
  input logic       drive_en_lo,
  input logic       drive_lvl_lo,
  input logic       drive_en_hi,
  input logic       lock_out
);
  AST_SAVE_HIZ_LO: assert property (@(posedge clk) disable iff (rst)
    save_lo |=> !drive_en_lo); // R7
  AST_SAVE_HIZ_HI: assert property (@(posedge clk) disable iff (rst)
    save_hi |=> !drive_en_hi); // R7
  AST_SAVED_COUNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!mon_en && save_lo && save_hi) |=> lock_out); // R6
  AST_MON_FB_HI: assert property (@(posedge clk) disable iff (rst)
    (mon_en && tsel == 2'b11) |=> (lock_out == $past(fb_hi))); // R9
  AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (rst)
    (drive_en_lo && $past(drive_en_lo) && $past($stable(pol_lo)))
      |-> $stable(drive_lvl_lo)); // R1
endmodule

bind pd_lock_top pd_lock_top_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fb_hi        (fb_hi),
  .pol_lo       (pol_lo),
  .save_lo      (save_lo),
  .save_hi      (save_hi),
  .mon_en       (mon_en),
  .tsel         (tsel),
  .drive_en_lo  (drive_en_lo),
  .drive_lvl_lo (drive_lvl_lo),
  .drive_en_hi  (drive_en_hi),
  .lock_out     (lock_out)
);

// File: tb/pd_lock_top_bench.sv
module pd_lock_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_lo = 0, fb_lo = 0, ref_hi = 0, fb_hi = 0;
  logic pol_lo = 1, pol_hi = 1, save_lo = 0, save_hi = 0;
  logic mon_en = 0;
  logic [1:0] tsel = 2'b00;
  logic drive_en_lo, drive_lvl_lo, drive_en_hi, drive_lvl_hi, lock_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pd_lock_top u_pd_lock_top (
    .clk(clk), .rst(rst),
    .ref_lo(ref_lo), .fb_lo(fb_lo), .ref_hi(ref_hi), .fb_hi(fb_hi),
    .pol_lo(pol_lo), .pol_hi(pol_hi), .save_lo(save_lo), .save_hi(save_hi),
    .mon_en(mon_en), .tsel(tsel),
    .drive_en_lo(drive_en_lo), .drive_lvl_lo(drive_lvl_lo),
    .drive_en_hi(drive_en_hi), .drive_lvl_hi(drive_lvl_hi),
    .lock_out(lock_out)
  );

  // lead d (positive: reference first), polarity, expected drive cycles, expected level
  localparam int VEC [8][4] = '{
    '{ 2, 1, 2, 1}, '{-2, 1, 2, 0}, '{ 2, 0, 2, 0}, '{-1, 0, 1, 1},
    '{ 0, 1, 0, 0}, '{ 1, 1, 1, 1}, '{ 5, 1, 5, 1}, '{-4, 0, 4, 1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmp(input bit hi, input int d, output int ncyc, output int lvl);
    int ad;
    logic a, b;
    ad = (d < 0) ? -d : d;
    ncyc = 0;
    lvl = 0;
    for (int i = 0; i <= ad + 3; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (hi ? drive_en_hi : drive_en_lo) begin
          ncyc++;
          lvl = int'(hi ? drive_lvl_hi : drive_lvl_lo);
        end
      end
      a = (i == 0);
      b = (i == ad);
      if (hi) begin
        ref_hi = (d >= 0) ? a : b;
        fb_hi  = (d >= 0) ? b : a;
      end else begin
        ref_lo = (d >= 0) ? a : b;
        fb_lo  = (d >= 0) ? b : a;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, l;
    int exp_pin [4];
    repeat (4) @(negedge clk);
    rst = 0;
    idle(2);
    check("R10 drive_en_lo after reset", int'(drive_en_lo), 0);
    check("R10 drive_en_hi after reset", int'(drive_en_hi), 0);
    check("R10 lock_out after reset", int'(lock_out), 0);

    save_hi = 1;
    idle(2);
    for (int v = 0; v < 8; v++) begin
      pol_lo = VEC[v][1][0];
      idle(1);
      run_cmp(0, VEC[v][0], n, l);
      if (VEC[v][2] == 0) check("R2 coincident edges drive cycles", n, 0);
      else begin
        check("R3 drive pulse width", n, VEC[v][2]);
        check("R1 drive level", l, VEC[v][3]);
      end
    end
    check("R4 unlocked after large lead", int'(lock_out), 0);

    pol_lo = 1;
    run_cmp(0, 1, n, l);
    check("R3 one-clock pulse", n, 1);
    run_cmp(0, 1, n, l);
    check("R5 two small errors not enough", int'(lock_out), 0);
    run_cmp(0, 1, n, l);
    check("R5 locked after three small errors", int'(lock_out), 1);
    run_cmp(0, 2, n, l);
    check("R5 mid error keeps lock", int'(lock_out), 1);
    run_cmp(0, -1, n, l);
    check("R3 pulse while locked", n, 1);
    run_cmp(0, 3, n, l);
    check("R4 lead of three unlocks", int'(lock_out), 0);
    run_cmp(0, 1, n, l);
    run_cmp(0, 0, n, l);
    run_cmp(0, 2, n, l);
    run_cmp(0, 1, n, l);
    run_cmp(0, 1, n, l);
    check("R5 mid error restarts run", int'(lock_out), 0);
    run_cmp(0, 1, n, l);
    check("R5 relock after fresh run", int'(lock_out), 1);

    save_hi = 0;
    idle(3);
    check("R6 unlocked active loop clears lock_out", int'(lock_out), 0);
    for (int k = 0; k < 3; k++) run_cmp(1, 0, n, l);
    check("R6 both loops locked", int'(lock_out), 1);
    run_cmp(1, 4, n, l);
    check("R6 one loop unlocked", int'(lock_out), 0);
    for (int k = 0; k < 3; k++) run_cmp(1, 0, n, l);

    run_cmp(0, 3, n, l);
    check("R4 low loop unlocked", int'(lock_out), 0);
    save_lo = 1;
    idle(3);
    check("R7 saved loop counts as locked", int'(lock_out), 1);
    run_cmp(0, 3, n, l);
    check("R7 no drive in power save", n, 0);
    check("R7 lock_out while saved", int'(lock_out), 1);
    save_lo = 0;
    idle(3);
    check("R6 lock_out after save release", int'(lock_out), 0);
    run_cmp(0, 2, n, l);
    check("R8 first comparison suppressed", n, 0);
    run_cmp(0, 2, n, l);
    check("R8 second comparison drives", n, 2);

    save_lo = 1;
    save_hi = 1;
    mon_en = 1;
    for (int p = 0; p < 2; p++) begin
      ref_lo = (p == 0); ref_hi = (p != 0); fb_lo = (p != 0); fb_hi = (p == 0);
      exp_pin[0] = int'(ref_lo); exp_pin[1] = int'(ref_hi);
      exp_pin[2] = int'(fb_lo);  exp_pin[3] = int'(fb_hi);
      for (int s = 0; s < 4; s++) begin
        tsel = 2'(s);
        idle(2);
        check("R9 monitor select", int'(lock_out), exp_pin[s]);
      end
    end
    ref_lo = 0; ref_hi = 0; fb_lo = 0; fb_hi = 0;
    mon_en = 0;
    idle(3);
    check("R6 lock path restored with both saved", int'(lock_out), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule